// File: doc/BRIEF.md
# Trace Packet Buffer with Loss Marker Request

This block sits between a trace packet formatter and the port that drives packets onto a trace bus. It holds up to 64 formatted packets and hands them out in arrival order through a valid/ready read port. It never stalls the formatter. Every cycle in which the formatter raises `wr_valid` consumes one packet. The packet is stored if a slot is free in that cycle. If no slot is free, the packet is discarded.

A discarded packet raises a sticky request, `ovf_req`, back to the formatter. In response the formatter emits a loss-marker packet once space exists, tagging that write with `ovf_ack`. The request falls at the clock edge that stores the tagged packet, so the marker takes its place in the stream after the surviving data. A slot freed by a read in the same cycle counts as space. The occupancy is a 7-bit level that can report both 0 and 64.

Top module: `trace_pkt_buffer`

## Requirements
- R1: After synchronous reset `rd_valid`=0, `level`=0, `ovf_req`=0 and `wr_ready`=1.
- R2: Packets leave in the order they were stored. `rd_data` holds steady while `rd_valid`=1 and `rd_ready`=0.
- R3: `rd_valid` is 1 exactly when `level` is non-zero. A `rd_ready` pulse while empty changes nothing.
- R4: The buffer stores 64 packets. With 64 stored and no read, `level`=64 and `wr_ready`=0. `level` never exceeds 64.
- R5: A write offered while `wr_ready`=0 is discarded. `level` stays unchanged and the packet never appears at `rd_data`.
- R6: A discarded write sets `ovf_req` to 1 from the next cycle.
- R7: `ovf_req` stays 1 through further discards and any cycles without a stored tagged write. No additional request is queued.
- R8: A write tagged with `ovf_ack` that is itself discarded neither stores the packet nor clears `ovf_req`.
- R9: With the buffer full, a read and a write in the same cycle store the write. `level` stays 64 and no loss is flagged.
- R10: A stored write tagged with `ovf_ack` clears `ovf_req` from the next cycle. The marker packet queues in order like any other packet.
- R11: A simultaneous read and write below full leaves `level` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Formatter offers a packet this cycle |
| wr_data | input | PKT_W | Packet from the formatter |
| ovf_ack | input | 1 | Marks the offered packet as the loss marker |
| wr_ready | output | 1 | A slot is available this cycle |
| ovf_req | output | 1 | Sticky loss-marker request to the formatter |
| rd_valid | output | 1 | Head packet available |
| rd_data | output | PKT_W | Head packet |
| rd_ready | input | 1 | Trace bus side takes the head packet |
| level | output | $clog2(DEPTH+1) | Stored packet count, 0 to 64 |

## Verification
Every cycle, the assertions check the level bound, that a discard or a full-buffer swap leaves the level unchanged, and that a stalled head stays stable. They also check how the request sets, holds and clears around discards and tagged writes. Only the bench scenarios can show that discarded packets are truly absent from the output stream. The same holds for the exact output order after a full buffer has been swapped into and drained, and for the marker landing behind the surviving data.

// File: rtl/tpb_pkg.sv
package tpb_pkg;

    // Per-cycle outcome of a write offer
    typedef struct packed {
        logic push;   // offer stored
        logic drop;   // offer discarded
    } tpb_wr_evt_t;

    typedef enum logic {
        REQ_IDLE    = 1'b0,
        REQ_PENDING = 1'b1
    } tpb_req_state_t;

    function automatic logic is_last_slot(input int unsigned idx, input int unsigned depth);
        return idx == depth - 1;
    endfunction

endpackage

// File: rtl/tpb_storage.sv
module tpb_storage #(
    parameter int PKT_W = 32,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [PKT_W-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [PKT_W-1:0] rdata
);
    logic [PKT_W-1:0] slots [DEPTH];

    always_ff @(posedge clk) begin
        if (we) slots[waddr] <= wdata;
    end

    assign rdata = slots[raddr];
endmodule

// File: rtl/tpb_occupancy.sv
module tpb_occupancy
    import tpb_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_valid,
    input  logic          rd_ready,
    output logic [AW-1:0] waddr,
    output logic [AW-1:0] raddr,
    output logic [CW-1:0] level,
    output logic          rd_valid,
    output logic          wr_ready,
    output tpb_wr_evt_t   evt
);
    localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);

    logic pop;

    assign rd_valid  = (level != '0);
    assign pop       = rd_valid && rd_ready;
    assign wr_ready  = (level != FULL_LVL) || pop;
    assign evt.push  = wr_valid && wr_ready;
    assign evt.drop  = wr_valid && !wr_ready;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return is_last_slot(int'(p), DEPTH) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            waddr <= '0;
            raddr <= '0;
            level <= '0;
        end else begin
            if (evt.push) waddr <= step(waddr);
            if (pop)      raddr <= step(raddr);
            unique case ({evt.push, pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    assert_level_bound_R4: assert property (@(posedge clk) disable iff (rst)
        level <= FULL_LVL);

    assert_drop_keeps_level_R5: assert property (@(posedge clk) disable iff (rst)
        evt.drop |=> $stable(level));

    assert_full_swap_R9: assert property (@(posedge clk) disable iff (rst)
        (level == FULL_LVL && evt.push && pop) |=> (level == FULL_LVL));

    assert_swap_level_R11: assert property (@(posedge clk) disable iff (rst)
        (evt.push && pop) |=> $stable(level));
endmodule

// File: rtl/tpb_ovf_ctrl.sv
module tpb_ovf_ctrl
    import tpb_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  tpb_wr_evt_t evt,
    input  logic        ovf_ack,
    output logic        ovf_req
);
    tpb_req_state_t state;
    logic           marker_stored;

    assign marker_stored = evt.push && ovf_ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= REQ_IDLE;
        end else if (evt.drop) begin
            state <= REQ_PENDING;
        end else if (marker_stored) begin
            state <= REQ_IDLE;
        end
    end

    assign ovf_req = (state == REQ_PENDING);

    assert_drop_sets_req_R6: assert property (@(posedge clk) disable iff (rst)
        evt.drop |=> ovf_req);

    assert_req_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (ovf_req && !marker_stored) |=> ovf_req);

    assert_lost_marker_keeps_req_R8: assert property (@(posedge clk) disable iff (rst)
        (ovf_req && evt.drop && ovf_ack) |=> ovf_req);

    assert_marker_clears_R10: assert property (@(posedge clk) disable iff (rst)
        marker_stored |=> !ovf_req);
endmodule

// File: rtl/trace_pkt_buffer.sv
module trace_pkt_buffer
    import tpb_pkg::*;
#(
    parameter int PKT_W = 32,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_valid,
    input  logic [PKT_W-1:0] wr_data,
    input  logic             ovf_ack,
    output logic             wr_ready,
    output logic             ovf_req,
    output logic             rd_valid,
    output logic [PKT_W-1:0] rd_data,
    input  logic             rd_ready,
    output logic [CW-1:0]    level
);
    tpb_wr_evt_t   evt;
    logic [AW-1:0] waddr;
    logic [AW-1:0] raddr;

    tpb_occupancy #(.DEPTH(DEPTH)) u_occ (
        .clk      (clk),
        .rst      (rst),
        .wr_valid (wr_valid),
        .rd_ready (rd_ready),
        .waddr    (waddr),
        .raddr    (raddr),
        .level    (level),
        .rd_valid (rd_valid),
        .wr_ready (wr_ready),
        .evt      (evt)
    );

    tpb_storage #(.PKT_W(PKT_W), .DEPTH(DEPTH)) u_mem (
        .clk   (clk),
        .we    (evt.push),
        .waddr (waddr),
        .wdata (wr_data),
        .raddr (raddr),
        .rdata (rd_data)
    );

    tpb_ovf_ctrl u_ovf (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt),
        .ovf_ack (ovf_ack),
        .ovf_req (ovf_req)
    );

    assert_head_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

    assert_empty_read_R3: assert property (@(posedge clk) disable iff (rst)
        (!rd_valid && !wr_valid) |=> !rd_valid);
endmodule

// File: tb/sim_trace_pkt_buffer.sv
module sim_trace_pkt_buffer;
    localparam int CLK_PERIOD = 10;
    localparam int PKT_W = 32;
    localparam int DEPTH = 64;
    localparam int CW = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst;
    logic             wr_valid, ovf_ack, rd_ready;
    logic [PKT_W-1:0] wr_data;
    logic             wr_ready, ovf_req, rd_valid;
    logic [PKT_W-1:0] rd_data;
    logic [CW-1:0]    level;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    trace_pkt_buffer #(.PKT_W(PKT_W), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data),
        .ovf_ack(ovf_ack), .wr_ready(wr_ready), .ovf_req(ovf_req),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_ready(rd_ready),
        .level(level)
    );

    // vector fields: wv[26] ack[25] data[24:17] rr[16] lvl[15:9] head[8:1] req[0]
    localparam int NV = 7;
    localparam logic [26:0] VEC [NV] = '{
        {1'b1, 1'b0, 8'h11, 1'b0, 7'd1, 8'h11, 1'b0},
        {1'b1, 1'b0, 8'h22, 1'b0, 7'd2, 8'h11, 1'b0},
        {1'b0, 1'b0, 8'h00, 1'b1, 7'd1, 8'h22, 1'b0},
        {1'b1, 1'b0, 8'h33, 1'b1, 7'd1, 8'h33, 1'b0},
        {1'b0, 1'b0, 8'h00, 1'b1, 7'd0, 8'h00, 1'b0},
        {1'b1, 1'b0, 8'h44, 1'b1, 7'd1, 8'h44, 1'b0},
        {1'b0, 1'b0, 8'h00, 1'b1, 7'd0, 8'h00, 1'b0}
    };

    task automatic chk(input string req, input logic [PKT_W-1:0] act, input logic [PKT_W-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive after an edge, let one edge pass, sample 1 time unit later
    task automatic step(input logic wv, input logic ack, input logic [PKT_W-1:0] d, input logic rr);
        wr_valid = wv; ovf_ack = ack; wr_data = d; rd_ready = rr;
        @(posedge clk); #1;
        wr_valid = 1'b0; ovf_ack = 1'b0; rd_ready = 1'b0;
    endtask

    initial begin
        rst = 1'b1; wr_valid = 1'b0; ovf_ack = 1'b0; rd_ready = 1'b0; wr_data = '0;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        // R1 reset state
        chk("R1 rd_valid", 32'(rd_valid), 32'd0);
        chk("R1 level", 32'(level), 32'd0);
        chk("R1 ovf_req", 32'(ovf_req), 32'd0);
        chk("R1 wr_ready", 32'(wr_ready), 32'd1);

        // table walk: order (R2), empty read (R3), swap below full (R11)
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][26], VEC[i][25], 32'(VEC[i][24:17]), VEC[i][16]);
            chk("R11 level", 32'(level), 32'(VEC[i][15:9]));
            chk("R3 rd_valid", 32'(rd_valid), 32'(VEC[i][15:9] != 0));
            if (VEC[i][15:9] != 0) chk("R2 head", rd_data, 32'(VEC[i][8:1]));
            chk("R6 ovf_req", 32'(ovf_req), 32'(VEC[i][0]));
        end

        // R4 fill to capacity
        for (int i = 0; i < DEPTH; i++) step(1'b1, 1'b0, 32'(i), 1'b0);
        chk("R4 level full", 32'(level), 32'd64);
        chk("R4 wr_ready low", 32'(wr_ready), 32'd0);
        chk("R2 hold head", rd_data, 32'd0);

        // R5/R6 discard while full
        step(1'b1, 1'b0, 32'hDEAD, 1'b0);
        chk("R5 level after drop", 32'(level), 32'd64);
        chk("R6 req set", 32'(ovf_req), 32'd1);
        // R7 further drop and idle cycles keep one request
        step(1'b1, 1'b0, 32'hBEEF, 1'b0);
        step(1'b0, 1'b0, 32'h0, 1'b0);
        chk("R7 req sticky", 32'(ovf_req), 32'd1);
        // R8 tagged write while full is lost
        step(1'b1, 1'b1, 32'hCAFE, 1'b0);
        chk("R8 req kept", 32'(ovf_req), 32'd1);
        chk("R8 level", 32'(level), 32'd64);
        // R9 swap while full
        step(1'b1, 1'b0, 32'h100, 1'b1);
        chk("R9 level", 32'(level), 32'd64);
        chk("R9 head advanced", rd_data, 32'd1);
        chk("R9 req unchanged", 32'(ovf_req), 32'd1);
        // free one slot, then store marker
        step(1'b0, 1'b0, 32'h0, 1'b1);
        chk("R4 level 63", 32'(level), 32'd63);
        step(1'b1, 1'b1, 32'hAAAA, 1'b0);
        chk("R10 req cleared", 32'(ovf_req), 32'd0);
        chk("R10 level", 32'(level), 32'd64);

        // drain: 2..63, 0x100, 0xAAAA (R2, R5 nothing discarded appears)
        for (int i = 0; i < DEPTH; i++) begin
            logic [PKT_W-1:0] e;
            e = (i < 62) ? 32'(i + 2) : (i == 62 ? 32'h100 : 32'hAAAA);
            chk("R2 drain order", rd_data, e);
            step(1'b0, 1'b0, 32'h0, 1'b1);
        end
        chk("R3 empty after drain", 32'(rd_valid), 32'd0);
        chk("R3 level zero", 32'(level), 32'd0);
        step(1'b0, 1'b0, 32'h0, 1'b1);
        chk("R3 read on empty", 32'(level), 32'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule